// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Resolver with Acknowledge Vectoring

This block joins two eight-input priority resolvers into one sixteen-line interrupt controller. External line k belongs to the first-level (primary) resolver when k is below 8 and to the second-level (secondary) resolver otherwise, on input k mod 8. Whenever the secondary resolver holds a request it may present, it feeds a one-shot request into primary input 2. The primary resolver's decision drives the processor interrupt pin.

When the processor acknowledges, the unit runs the acknowledge on the primary resolver. If the primary picks input 2, it also runs the acknowledge on the secondary. It then forms an 8-bit vector from a 5-bit base and a 3-bit line number. If a resolver has nothing to offer at that moment, the vector names line 7 of that resolver and is flagged as spurious.

The acknowledge request and the returned vector use valid/ready handshakes. An acknowledge is accepted only when no vector is waiting, so a stalled vector consumer also holds off further acknowledges. A vector, once raised, stays unchanged until it is taken. Masks, trigger modes, vector bases and end-of-service commands are plain control pins.

Top module: `cascade_ack_unit`

## Requirements
- R1: After reset no request is pending and no line is in service. `cpu_int` and `vec_valid` are 0 and `ack_ready` is 1.
- R2: Line k maps to resolver k>>3, input k&7. In edge mode a 0-to-1 change latches a request. For an unmasked primary line with nothing in service, `cpu_int` is 1 after one clock edge.
- R3: Each resolver picks its lowest-numbered pending unmasked input. It raises a request only if that input is numbered lower than its lowest in-service input. A masked line keeps its latched request but does not raise `cpu_int` until it is unmasked.
- R4: Each cycle the secondary resolver has a request it may present, a request is latched on primary input 2. For a secondary line, `cpu_int` is 1 after two edges. External line 2 is ignored.
- R5: An acknowledge that resolves primary input j (j not 2) returns vector `mst_base`*8+j with `vec_spurious`=0. It marks j in service and clears an edge-mode request on j.
- R6: An acknowledge that resolves primary input 2 also acknowledges the secondary resolver. It returns `slv_base`*8+s, where s is the secondary line chosen. Primary input 2 and secondary input s both become in service.
- R7: If the primary has no request at acknowledge, the vector is `mst_base`*8+7 with `vec_spurious`=1, and no in-service bit is set.
- R8: If the primary resolves input 2 but the secondary has no request, the vector is `slv_base`*8+7 with `vec_spurious`=1. Secondary in-service bits are left unchanged.
- R9: A line whose `irq_level_mode` bit is 1 has a request equal to its current level. An acknowledge does not clear it.
- R10: `vec_valid` rises one cycle after an accepted acknowledge. While `vec_valid`=1 and `vec_ready`=0, `vec_data` is held and `ack_ready` is 0.
- R11: An `eoi_valid` pulse clears the in-service bit of line `eoi_line` (bit 3 picks the resolver). Lower-priority requests then become eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | External request lines |
| irq_mask | input | 16 | 1 masks the line |
| irq_level_mode | input | 16 | 1 selects level trigger, 0 edge trigger |
| mst_base | input | 5 | Primary vector base (upper 5 bits) |
| slv_base | input | 5 | Secondary vector base (upper 5 bits) |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_line | input | 4 | Line whose in-service bit is cleared |
| ack_valid | input | 1 | Processor acknowledge request |
| ack_ready | output | 1 | Acknowledge can be accepted |
| vec_valid | output | 1 | Vector available |
| vec_ready | input | 1 | Vector consumer takes the vector |
| vec_data | output | 8 | Interrupt vector |
| vec_spurious | output | 1 | Vector is a spurious line-7 report |
| cpu_int | output | 1 | Interrupt request to the processor |

## Verification
Inputs change on the falling edge and outputs are read on the next falling edge, so every count below is a number of rising edges.

- Request to `cpu_int`: a primary-line edge shows on `cpu_int` after one rising edge, and a secondary-line edge after two. The second edge is the cascade latch into primary input 2. The bench checks a secondary line at both points: still low after the first edge, high after the second.
- Acknowledge to vector: the vector appears one edge after the acknowledge is accepted, and that is where the bench reads it.
- In-service state: its effects on `cpu_int` are read one edge after the acknowledge or end-of-service that changes them.
- Mask and handshake: mask changes act at once, because the mask feeds the resolver combinationally. The bench reads them at the next falling edge, and it reads `ack_ready` the same way against a held vector.

// File: rtl/cack_pkg.sv
`timescale 1ns/1ps
package cack_pkg;
  localparam int unsigned CTL_LINES = 8;
  localparam int unsigned CTL_LW    = $clog2(CTL_LINES);

  typedef struct packed {
    logic                 found;
    logic [CTL_LW-1:0]    idx;
  } pick_t;
endpackage

// File: rtl/cack_prio_pick.sv
`timescale 1ns/1ps
module cack_prio_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [LW-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = i[LW-1:0];
      end
    end
  end
endmodule

// File: rtl/cack_resolver.sv
`timescale 1ns/1ps
module cack_resolver #(
  parameter int unsigned N  = 8,
  localparam int unsigned LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  lines,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  lvl_mode,
  input  logic [N-1:0]  extra_set,
  input  logic          ack,
  input  logic          eoi,
  input  logic [LW-1:0] eoi_idx,
  output logic          int_req,
  output logic [LW-1:0] int_line
);
  logic [N-1:0]  irr_q, isr_q, last_q;
  logic [N-1:0]  pend, rise, ack_bit, eoi_bit;
  logic [N-1:0]  irr_edge_n, irr_n, isr_n;
  logic          p_found, s_found;
  logic [LW-1:0] p_idx, s_idx;

  assign pend = irr_q & ~mask;

  cack_prio_pick #(.N(N)) pick_req_i (
    .req(pend), .found(p_found), .idx(p_idx)
  );
  cack_prio_pick #(.N(N)) pick_isr_i (
    .req(isr_q), .found(s_found), .idx(s_idx)
  );

  // a request is presented only if it outranks everything in service
  assign int_req  = p_found && (!s_found || (p_idx < s_idx));
  assign int_line = p_idx;

  always_comb begin
    ack_bit = '0;
    eoi_bit = '0;
    if (ack && int_req) ack_bit[p_idx] = 1'b1;
    if (eoi)            eoi_bit[eoi_idx] = 1'b1;
  end

  assign rise       = lines & ~last_q;
  assign irr_edge_n = (irr_q & ~ack_bit) | rise | extra_set;

  // level-mode bits follow the pin; edge-mode bits latch and clear on ack
  generate
    for (genvar g = 0; g < N; g++) begin : g_bit
      assign irr_n[g] = lvl_mode[g] ? lines[g] : irr_edge_n[g];
    end
  endgenerate

  assign isr_n = (isr_q & ~eoi_bit) | ack_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      last_q <= lines;
    end
  end
endmodule

// File: rtl/cascade_ack_unit.sv
`timescale 1ns/1ps
module cascade_ack_unit #(
  parameter int unsigned LINES    = 8,
  parameter int unsigned CAS_LINE = 2,
  parameter int unsigned VEC_W    = 8,
  localparam int unsigned LW      = $clog2(LINES),
  localparam int unsigned TOT     = 2 * LINES,
  localparam int unsigned BASE_W  = VEC_W - LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TOT-1:0]    irq_lines,
  input  logic [TOT-1:0]    irq_mask,
  input  logic [TOT-1:0]    irq_level_mode,
  input  logic [BASE_W-1:0] mst_base,
  input  logic [BASE_W-1:0] slv_base,
  input  logic              eoi_valid,
  input  logic [LW:0]       eoi_line,
  input  logic              ack_valid,
  output logic              ack_ready,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [VEC_W-1:0]  vec_data,
  output logic              vec_spurious,
  output logic              cpu_int
);
  localparam logic [LINES-1:0] CAS_MASK  = LINES'(1) << CAS_LINE;
  localparam logic [LW-1:0]    SPUR_LINE = LW'(LINES - 1);

  logic          m_int, s_int;
  logic [LW-1:0] m_line, s_line;
  logic          ack_fire, m_ack, s_ack;
  logic          m_eoi, s_eoi;
  logic [LINES-1:0] cas_set;
  logic [VEC_W-1:0] vec_n;
  logic             spur_n;
  logic [VEC_W-1:0] vec_q;
  logic             spur_q, vld_q;

  assign ack_ready = !vld_q || vec_ready;
  assign ack_fire  = ack_valid && ack_ready;
  assign m_ack     = ack_fire;
  assign s_ack     = ack_fire && m_int && (m_line == LW'(CAS_LINE));

  assign m_eoi = eoi_valid && !eoi_line[LW];
  assign s_eoi = eoi_valid &&  eoi_line[LW];

  // secondary request pulses primary cascade input; suppressed in the
  // cycle the secondary itself is being acknowledged
  assign cas_set = (s_int && !s_ack) ? CAS_MASK : '0;

  cack_resolver #(.N(LINES)) mst_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_lines[LINES-1:0] & ~CAS_MASK),
    .mask     (irq_mask[LINES-1:0]),
    .lvl_mode (irq_level_mode[LINES-1:0] & ~CAS_MASK),
    .extra_set(cas_set),
    .ack      (m_ack),
    .eoi      (m_eoi),
    .eoi_idx  (eoi_line[LW-1:0]),
    .int_req  (m_int),
    .int_line (m_line)
  );

  cack_resolver #(.N(LINES)) slv_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_lines[TOT-1:LINES]),
    .mask     (irq_mask[TOT-1:LINES]),
    .lvl_mode (irq_level_mode[TOT-1:LINES]),
    .extra_set('0),
    .ack      (s_ack),
    .eoi      (s_eoi),
    .eoi_idx  (eoi_line[LW-1:0]),
    .int_req  (s_int),
    .int_line (s_line)
  );

  always_comb begin
    if (!m_int) begin
      vec_n  = {mst_base, SPUR_LINE};
      spur_n = 1'b1;
    end else if (m_line == LW'(CAS_LINE)) begin
      vec_n  = s_int ? {slv_base, s_line} : {slv_base, SPUR_LINE};
      spur_n = !s_int;
    end else begin
      vec_n  = {mst_base, m_line};
      spur_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      vec_q  <= '0;
      spur_q <= 1'b0;
    end else if (ack_fire) begin
      vld_q  <= 1'b1;
      vec_q  <= vec_n;
      spur_q <= spur_n;
    end else if (vec_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign vec_valid    = vld_q;
  assign vec_data     = vec_q;
  assign vec_spurious = spur_q;
  assign cpu_int      = m_int;
endmodule

// File: rtl/cascade_ack_unit_chk.sv
`timescale 1ns/1ps
module cascade_ack_unit_chk #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned LW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_valid,
  input logic             ack_ready,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic [VEC_W-1:0] vec_data,
  input logic             vec_spurious,
  input logic             cpu_int
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!vec_valid && !cpu_int));

  assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data) && $stable(vec_spurious)));

  assert_vec_follows_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready) |=> vec_valid);

  assert_no_ack_while_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |-> !ack_ready);

  assert_spurious_line7_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_spurious) |-> (vec_data[LW-1:0] == {LW{1'b1}}));
endmodule

bind cascade_ack_unit cascade_ack_unit_chk #(.VEC_W(VEC_W), .LW(LW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_valid   (ack_valid),
  .ack_ready   (ack_ready),
  .vec_valid   (vec_valid),
  .vec_ready   (vec_ready),
  .vec_data    (vec_data),
  .vec_spurious(vec_spurious),
  .cpu_int     (cpu_int)
);

// File: tb/cascade_ack_unit_tb_top.sv
`timescale 1ns/1ps
module cascade_ack_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_lines, irq_mask, irq_level_mode;
  logic [4:0]  mst_base, slv_base;
  logic        eoi_valid;
  logic [3:0]  eoi_line;
  logic        ack_valid, ack_ready, vec_valid, vec_ready, vec_spurious, cpu_int;
  logic [7:0]  vec_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  cascade_ack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .irq_mask(irq_mask),
    .irq_level_mode(irq_level_mode), .mst_base(mst_base), .slv_base(slv_base),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line), .ack_valid(ack_valid),
    .ack_ready(ack_ready), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data), .vec_spurious(vec_spurious), .cpu_int(cpu_int)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    irq_lines = '0; irq_mask = '0; irq_level_mode = '0;
    eoi_valid = 1'b0; eoi_line = '0; ack_valid = 1'b0; vec_ready = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_ack(output int v, output int sp);
    ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    check("R10 vec_valid after ack", int'(vec_valid), 1);
    v  = int'(vec_data);
    sp = int'(vec_spurious);
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
  endtask

  task automatic do_eoi(input int line);
    eoi_valid = 1'b1;
    eoi_line  = 4'(line);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, sp, mb, sb;
    mst_base = 5'd4; slv_base = 5'd14;
    do_reset();
    // R1 reset state
    check("R1 cpu_int", int'(cpu_int), 0);
    check("R1 vec_valid", int'(vec_valid), 0);
    check("R1 ack_ready", int'(ack_ready), 1);

    // sweep every line except the cascade input: R2, R4, R5, R6, R11
    for (int k = 0; k < 16; k++) begin
      if (k == 2) continue;
      mb = k + 1; sb = 30 - k;
      mst_base = 5'(mb); slv_base = 5'(sb);
      irq_lines[k] = 1'b1;
      @(negedge clk);
      if (k < 8) begin
        check("R2 cpu_int after one edge", int'(cpu_int), 1);
      end else begin
        check("R4 cpu_int low after one edge", int'(cpu_int), 0);
        @(negedge clk);
        check("R4 cpu_int after two edges", int'(cpu_int), 1);
      end
      do_ack(v, sp);
      if (k < 8) check("R5 vector", v, mb * 8 + k);
      else       check("R6 vector", v, sb * 8 + (k - 8));
      check("R5 spurious flag", sp, 0);
      check("R5 in service blocks line", int'(cpu_int), 0);
      do_eoi(k);
      if (k >= 8) do_eoi(2);
      check("R5 edge request cleared by ack", int'(cpu_int), 0);
      irq_lines[k] = 1'b0;
      @(negedge clk);
    end

    // R4 external line 2 ignored; R7 spurious on primary
    do_reset();
    mst_base = 5'd9; slv_base = 5'd20;
    irq_lines[2] = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 external line 2 ignored", int'(cpu_int), 0);
    do_ack(v, sp);
    check("R7 spurious vector", v, 9 * 8 + 7);
    check("R7 spurious flag", sp, 1);
    irq_lines[2] = 1'b0;
    irq_lines[7] = 1'b1;
    @(negedge clk);
    check("R7 no in-service set by spurious", int'(cpu_int), 1);
    do_ack(v, sp);
    check("R7 real line 7 vector", v, 9 * 8 + 7);
    check("R7 real line 7 flag", sp, 0);
    do_eoi(7);
    irq_lines[7] = 1'b0;

    // R3 priority and nesting; R11 end of service
    do_reset();
    irq_lines[5] = 1'b1; irq_lines[3] = 1'b1;
    @(negedge clk);
    do_ack(v, sp);
    check("R3 lowest line first", v, 9 * 8 + 3);
    check("R3 lower priority held off", int'(cpu_int), 0);
    do_eoi(3);
    check("R11 eoi releases lower line", int'(cpu_int), 1);
    do_ack(v, sp);
    check("R3 second vector", v, 9 * 8 + 5);
    do_eoi(5);
    irq_lines[5] = 1'b0; irq_lines[3] = 1'b0;

    // R3 primary line 1 beats cascaded line 8
    do_reset();
    irq_lines[1] = 1'b1; irq_lines[8] = 1'b1;
    repeat (2) @(negedge clk);
    do_ack(v, sp);
    check("R3 primary 1 over cascade", v, 9 * 8 + 1);
    do_eoi(1);
    do_ack(v, sp);
    check("R6 cascaded line 8", v, 20 * 8 + 0);
    do_eoi(8); do_eoi(2);
    irq_lines[1] = 1'b0; irq_lines[8] = 1'b0;

    // R3 mask holds request
    do_reset();
    irq_mask[4] = 1'b1; irq_lines[4] = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 masked line quiet", int'(cpu_int), 0);
    irq_mask[4] = 1'b0;
    @(negedge clk);
    check("R3 unmasked latched request", int'(cpu_int), 1);
    do_ack(v, sp);
    check("R3 unmasked vector", v, 9 * 8 + 4);
    do_eoi(4);
    irq_lines[4] = 1'b0;

    // R9 level mode
    do_reset();
    irq_level_mode[6] = 1'b1; irq_lines[6] = 1'b1;
    @(negedge clk);
    check("R9 level request", int'(cpu_int), 1);
    do_ack(v, sp);
    check("R9 level vector", v, 9 * 8 + 6);
    check("R9 in service blocks", int'(cpu_int), 0);
    do_eoi(6);
    check("R9 level request survives ack", int'(cpu_int), 1);
    irq_lines[6] = 1'b0;
    @(negedge clk);
    check("R9 level request follows pin", int'(cpu_int), 0);

    // R8 secondary spurious
    do_reset();
    irq_lines[9] = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 cascade raised", int'(cpu_int), 1);
    irq_mask[9] = 1'b1;
    @(negedge clk);
    check("R4 cascade request latched", int'(cpu_int), 1);
    do_ack(v, sp);
    check("R8 secondary spurious vector", v, 20 * 8 + 7);
    check("R8 secondary spurious flag", sp, 1);
    irq_lines[9] = 1'b0;
    do_eoi(2);
    irq_lines[15] = 1'b1;
    @(negedge clk);
    check("R8 line 15 one edge", int'(cpu_int), 0);
    @(negedge clk);
    check("R8 secondary isr untouched", int'(cpu_int), 1);
    do_ack(v, sp);
    check("R8 real line 15 vector", v, 20 * 8 + 7);
    check("R8 real line 15 flag", sp, 0);
    irq_lines[15] = 1'b0;

    // R10 back-pressure
    do_reset();
    irq_lines[0] = 1'b1;
    @(negedge clk);
    ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    check("R10 vec_valid one cycle after ack", int'(vec_valid), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 vector held", int'(vec_valid), 1);
      check("R10 data held", int'(vec_data), 9 * 8 + 0);
      check("R10 ack blocked", int'(ack_ready), 0);
    end
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
    check("R10 vector taken", int'(vec_valid), 0);
    check("R10 ack ready again", int'(ack_ready), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule